// File: doc/BRIEF.md
# Nap-Mode Clock Power Controller

This block decides which internal clock enables of a processor core are active. When software asks for a low-power nap, the controller first waits for the core to report that it is idle. It then turns off every core clock enable except two: the one for interrupt detection and the one for clock generation. Those two stay on at all times. A synchronized external interrupt is the only event that ends the nap and brings every enable back.

While the core naps, the system can raise a run input to switch the core clocks back on so that bus snoop traffic can be served. This does not end the nap. Once run is dropped and snoop work has finished, the clocks are gated again.

The block also produces a bus-sample strobe for the core side. The strobe matches the selected ratio of core clock to bus clock, which can be 1, 1.5, 2 or 3.

Top module: `nap_clk_ctrl`

## Requirements
- R1: After reset the controller is in the running state. All core clock enables are high, `nap_active_o` is low, and the strobe phase starts at its first position, so `bus_stb_o` is high in the first cycle after reset.
- R2: A nap starts only when `nap_req_i` is seen high in the running state. The controller then waits in an entry state, with all core enables still high, until `core_idle_i` is high. The clocks are gated in the cycle after that.
- R3: In the nap state every bit of `core_clk_en_o` is low. `irq_clk_en_o` and `pll_clk_en_o` are high in every state.
- R4: `irq_i` passes through a two-flop synchronizer. If `irq_i` is high at edge k while the core is napping, the controller is running again after edge k+2, with all core enables high and `nap_active_o` low.
- R5: In the nap state, `run_i` high moves the controller to a snoop state on the next edge. In the snoop state all core enables are high and `nap_active_o` stays high.
- R6: The controller leaves the snoop state for the nap state only on an edge where both `run_i` and `snoop_busy_i` are low.
- R7: `ratio_sel_i` selects the strobe pattern, encoded as 0 for 1:1, 1 for 1.5:1, 2 for 2:1 and 3 for 3:1. Ratio 1 strobes every cycle. Ratio 1.5 repeats a three-cycle pattern of high, high, low, so the gaps between strobes are 1 and then 2 cycles. Ratio 2 strobes once every 2 cycles and ratio 3 once every 3 cycles.
- R8: `nap_active_o` is high exactly while the controller is in the nap or snoop state.
- R9: `nap_req_i` has no effect outside the running state. A synchronized interrupt seen during the entry state returns the controller to running without gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nap_req_i | input | 1 | Software nap request from the core |
| core_idle_i | input | 1 | Core reports that it has drained and is idle |
| irq_i | input | 1 | External interrupt, asynchronous |
| run_i | input | 1 | Re-enable clocks during a nap for snoop service |
| snoop_busy_i | input | 1 | Snoop work still in progress |
| ratio_sel_i | input | 2 | Core-to-bus ratio code (0:1, 1:1.5, 2:2, 3:3) |
| core_clk_en_o | output | NUM_CORE_EN | Clock enables for the gated core domains |
| irq_clk_en_o | output | 1 | Clock enable for interrupt detection logic |
| pll_clk_en_o | output | 1 | Clock enable for clock generation logic |
| nap_active_o | output | 1 | High while napping, including snoop service |
| bus_stb_o | output | 1 | Bus-sample strobe on core clock |

## Verification
Some properties are checked by assertions on every cycle:
- Core enables are either all high or all low, and they are low only during a nap.
- Interrupt detection and clock generation stay enabled at all times.
- A synchronized interrupt during a nap always wakes the core on the next edge.
- The snoop state holds while run or snoop-busy is high.
- Entry into nap is always preceded by an idle acknowledge.
- The strobe spacing for ratios 1 and 2 is correct.

Other behaviours can only be shown by the bench scenarios, which compare the outputs against a reference model on every clock:
- The exact two-edge latency of the interrupt synchronizer.
- The 1.5 and 3 strobe patterns.
- That requests are ignored while napping.
- That an interrupt during entry aborts the nap.

// File: rtl/nap_pkg.sv
package nap_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_NAP   = 2'd2,
    ST_SNOOP = 2'd3
  } nap_state_e;

  localparam int PHASE_W = 2;

  // Length of the strobe pattern for a ratio code
  function automatic logic [PHASE_W-1:0] ratio_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd1;
      2'd1:    return 2'd3;
      2'd2:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Strobe value for a ratio code at a given phase
  function automatic logic ratio_strobe(input logic [1:0] sel, input logic [PHASE_W-1:0] ph);
    case (sel)
      2'd0:    return 1'b1;
      2'd1:    return (ph != 2'd2);
      default: return (ph == 2'd0);
    endcase
  endfunction

endpackage

// File: rtl/nap_irq_sync.sv
module nap_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import nap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nap_req_i,
  input  logic       core_idle_i,
  input  logic       irq_sync_i,
  input  logic       run_i,
  input  logic       snoop_busy_i,
  output nap_state_e state_o
);
  nap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (nap_req_i) state_d = ST_ENTER;
      end
      ST_ENTER: begin
        if (irq_sync_i)       state_d = ST_RUN;
        else if (core_idle_i) state_d = ST_NAP;
      end
      ST_NAP: begin
        if (irq_sync_i) state_d = ST_RUN;
        else if (run_i) state_d = ST_SNOOP;
      end
      ST_SNOOP: begin
        if (irq_sync_i)                   state_d = ST_RUN;
        else if (!run_i && !snoop_busy_i) state_d = ST_NAP;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/nap_bus_strobe.sv
module nap_bus_strobe
  import nap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel_i,
  output logic       stb_o
);
  logic [PHASE_W-1:0] phase_q, phase_d, period;

  always_comb begin
    period  = ratio_period(ratio_sel_i);
    phase_d = (phase_q >= period - 1'b1) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign stb_o = ratio_strobe(ratio_sel_i, phase_q);
endmodule

// File: rtl/nap_clk_ctrl.sv
module nap_clk_ctrl
  import nap_pkg::*;
#(
  parameter int NUM_CORE_EN = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nap_req_i,
  input  logic                   core_idle_i,
  input  logic                   irq_i,
  input  logic                   run_i,
  input  logic                   snoop_busy_i,
  input  logic [1:0]             ratio_sel_i,
  output logic [NUM_CORE_EN-1:0] core_clk_en_o,
  output logic                   irq_clk_en_o,
  output logic                   pll_clk_en_o,
  output logic                   nap_active_o,
  output logic                   bus_stb_o
);
  logic       irq_sync;
  nap_state_e state;

  nap_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_i), .sync_o(irq_sync)
  );

  nap_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .nap_req_i(nap_req_i), .core_idle_i(core_idle_i),
    .irq_sync_i(irq_sync), .run_i(run_i), .snoop_busy_i(snoop_busy_i),
    .state_o(state)
  );

  nap_bus_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .ratio_sel_i(ratio_sel_i), .stb_o(bus_stb_o)
  );

  assign core_clk_en_o = (state == ST_NAP) ? '0 : '1;
  assign irq_clk_en_o  = 1'b1;
  assign pll_clk_en_o  = 1'b1;
  assign nap_active_o  = (state == ST_NAP) || (state == ST_SNOOP);
endmodule

// File: rtl/nap_clk_ctrl_chk.sv
module nap_clk_ctrl_chk #(
  parameter int NUM_CORE_EN = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   core_idle_i,
  input logic                   run_i,
  input logic                   snoop_busy_i,
  input logic [1:0]             ratio_sel_i,
  input logic                   irq_sync,
  input logic [NUM_CORE_EN-1:0] core_clk_en_o,
  input logic                   irq_clk_en_o,
  input logic                   pll_clk_en_o,
  input logic                   nap_active_o,
  input logic                   bus_stb_o
);
  assert_gated_only_in_nap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en_o != '1) |-> (core_clk_en_o == '0 && nap_active_o));

  assert_always_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clk_en_o && pll_clk_en_o);

  assert_irq_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_active_o && irq_sync) |=> (!nap_active_o && core_clk_en_o == '1));

  assert_snoop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_active_o && core_clk_en_o == '1 && (run_i || snoop_busy_i) && !irq_sync)
      |=> (nap_active_o && core_clk_en_o == '1));

  assert_entry_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nap_active_o && !core_idle_i) |=> !nap_active_o);

  assert_ratio_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_sel_i == 2'd0) |-> bus_stb_o);

  assert_ratio_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb_o && ratio_sel_i == 2'd2) |=> ($stable(ratio_sel_i) -> !bus_stb_o));
endmodule

bind nap_clk_ctrl nap_clk_ctrl_chk #(.NUM_CORE_EN(NUM_CORE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_idle_i(core_idle_i), .run_i(run_i),
  .snoop_busy_i(snoop_busy_i), .ratio_sel_i(ratio_sel_i), .irq_sync(irq_sync),
  .core_clk_en_o(core_clk_en_o), .irq_clk_en_o(irq_clk_en_o),
  .pll_clk_en_o(pll_clk_en_o), .nap_active_o(nap_active_o), .bus_stb_o(bus_stb_o)
);

// File: tb/nap_clk_ctrl_tb_top.sv
module nap_clk_ctrl_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, nap_req, core_idle, irq, run, sbusy;
  logic [1:0] ratio;
  logic [N-1:0] core_en;
  logic irq_en, pll_en, nap_act, stb;

  nap_clk_ctrl #(.NUM_CORE_EN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .nap_req_i(nap_req), .core_idle_i(core_idle),
    .irq_i(irq), .run_i(run), .snoop_busy_i(sbusy), .ratio_sel_i(ratio),
    .core_clk_en_o(core_en), .irq_clk_en_o(irq_en), .pll_clk_en_o(pll_en),
    .nap_active_o(nap_act), .bus_stb_o(stb)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model: 0 run, 1 entry, 2 nap, 3 snoop
  int m_st, m_s1, m_s2, m_cyc;
  int stb_q[$];

  function automatic int period_of(input logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd2) ? 2 : 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_s1 = 0; m_s2 = 0; m_cyc = 0;
    end else begin
      case (m_st)
        0: if (nap_req) m_st = 1;
        1: if (m_s2 != 0) m_st = 0; else if (core_idle) m_st = 2;
        2: if (m_s2 != 0) m_st = 0; else if (run) m_st = 3;
        3: if (m_s2 != 0) m_st = 0; else if (!run && !sbusy) m_st = 2;
        default: m_st = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = int'(irq);
      if (m_cyc >= period_of(ratio) - 1) m_cyc = 0; else m_cyc = m_cyc + 1;
    end
  end

  function automatic bit exp_stb(input logic [1:0] r, input int c);
    case (r)
      2'd0: return 1'b1;
      2'd1: return c != 2;
      default: return c == 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_en;
      exp_en = (m_st == 2) ? 0 : (1 << N) - 1;
      chk(int'(core_en) == exp_en, (m_st == 3) ? "R5 core_en" : "R3 core_en", int'(core_en), exp_en);
      chk(irq_en && pll_en, "R3 always-on", int'({irq_en, pll_en}), 3);
      chk(nap_act == (m_st >= 2), "R8 nap_active", int'(nap_act), int'(m_st >= 2));
      chk(stb == exp_stb(ratio, m_cyc), "R7 bus_stb", int'(stb), int'(exp_stb(ratio, m_cyc)));
      stb_q.push_back(int'(stb));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; nap_req = 0; core_idle = 0; irq = 0; run = 0; sbusy = 0; ratio = 2'd0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(nap_act == 1'b0 && core_en == '1 && stb == 1'b1, "R1 reset", int'({nap_act, stb}), 1);

    // R7: sweep ratios
    for (int r = 0; r < 4; r++) begin
      ratio = r[1:0];
      cyc(12);
    end
    ratio = 2'd1;

    // R2: request, idle delayed
    nap_req = 1; cyc(1); nap_req = 0;
    cyc(3);
    chk(core_en == '1 && !nap_act, "R2 waiting for idle", int'(core_en), (1 << N) - 1);
    core_idle = 1; cyc(1); core_idle = 0;
    chk(core_en == '0 && nap_act, "R2 gated after idle", int'(core_en), 0);
    cyc(4);

    // R9: request while napping is ignored
    nap_req = 1; cyc(2); nap_req = 0;
    chk(core_en == '0 && nap_act, "R9 request ignored in nap", int'(core_en), 0);

    // R5/R6: snoop window with busy trailing
    run = 1; cyc(1);
    chk(core_en == '1 && nap_act, "R5 snoop clocks on", int'(core_en), (1 << N) - 1);
    cyc(3);
    sbusy = 1; run = 0; cyc(2);
    chk(core_en == '1 && nap_act, "R6 busy holds snoop", int'(core_en), (1 << N) - 1);
    sbusy = 0; cyc(1);
    chk(core_en == '0 && nap_act, "R6 back to nap", int'(core_en), 0);
    cyc(3);

    // R4: interrupt wakes after two sync edges
    irq = 1; cyc(1); irq = 0;
    chk(nap_act, "R4 still napping after one edge", int'(nap_act), 1);
    cyc(1);
    chk(nap_act, "R4 still napping after sync stage", int'(nap_act), 1);
    cyc(1);
    chk(!nap_act && core_en == '1, "R4 awake", int'(nap_act), 0);
    cyc(4);

    // R9: interrupt during entry aborts
    ratio = 2'd3;
    nap_req = 1; cyc(1); nap_req = 0;
    irq = 1; cyc(1); irq = 0; cyc(2);
    core_idle = 1; cyc(1); core_idle = 0;
    chk(!nap_act && core_en == '1, "R9 entry aborted", int'(nap_act), 0);
    cyc(3);

    // R4: interrupt during snoop also wakes
    ratio = 2'd2;
    nap_req = 1; core_idle = 1; cyc(2); nap_req = 0; core_idle = 0;
    run = 1; cyc(2);
    irq = 1; cyc(1); irq = 0; cyc(2);
    run = 0;
    chk(!nap_act, "R4 wake from snoop", int'(nap_act), 0);
    cyc(6);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule